// File: doc/BRIEF.md
# Always-On Millisecond Timer with Alarm

This block keeps a 64-bit count of milliseconds. The count advances by one on every 1 kHz tick. The tick comes from one of three places. Two of them are fractional dividers, one running from a low-power oscillator strobe and one from a crystal oscillator strobe. Each divider is programmed with its oscillator's rate in kHz, split into a 16-bit whole part and a 16-bit fraction. The third source is the rising edge of one chosen input pin that already carries a 1 kHz tick. A comparator against a 64-bit alarm time raises a latched interrupt and, when enabled, a power-up request.

All writes arrive on a simple register port. A write counts only if its upper half carries a fixed key, and the useful data sits in the lower 16 bits. The 64-bit time and the 64-bit alarm are each loaded through four 16-bit slice registers. The time is read back as a lower and an upper 32-bit word. Software reads the upper word, then the lower word, then the upper word again, to catch a carry between the reads.

When software picks a different tick source, the change takes effect after a fixed number of clock cycles. During that window the old source keeps counting. A per-source "in use" flag confirms the switch once it is done.

Top module: `aon_ms_timer`

## Requirements
- R1: A write whose bits 31:16 differ from the key `PASSWORD` (default 16'h5AFE) changes no state.
- R2: Writes to addresses 1 to 4 load the counter's 16-bit slices: address 1 holds bits 15:0, address 2 bits 31:16, address 3 bits 47:32 and address 4 bits 63:48. Such writes are ignored while the run bit is set.
- R3: The read port is combinational. `rd_addr` 1 returns counter bits 31:0 and `rd_addr` 2 returns bits 63:32.
- R4: While running, the counter adds exactly one per tick from the active source. While stopped, it holds its value.
- R5: An oscillator divider adds 1.0 to its accumulator on each strobe of its own oscillator. When the accumulator reaches the programmed value (whole part and 16-bit fraction), the divider ticks and keeps the excess. With a setting of 3.5, the ticks fall on the 4th strobe and then on the 3rd strobe after it. A divider is cleared while it is not the running source.
- R6: The pin source ticks on a rising edge of `tick_pins[idx]`, about three cycles after the edge because of the two-stage synchroniser. Writes to the pin-index register (address 13) are accepted only for 12, 14, 20 or 22; any other value is ignored.
- R7: The control register (address 0) holds source-select bits in [2:0] (bit 0 low-power oscillator, bit 1 crystal, bit 2 pin; the highest set bit wins), run in [3], alarm enable in [4] and power-up-on-alarm in [5]. After a switch to a different source, the in-use flags (read at control bits [10:8]) are zero for `SW_DELAY` cycles and the old source still ticks. After that, the new source's flag is set while running.
- R8: The alarm slices (addresses 5 to 8, in the same bit order as the counter slices) are written only while alarm enable is clear.
- R9: While alarm enable is set and the counter is at or past the alarm time, `irq` is set on the next clock. It stays set until a write to address 14 with bit 0 set, and a pending clear wins over a new firing in that same cycle.
- R10: `pwrup_req` is high exactly when `irq` is high and power-up-on-alarm is set.
- R11: After reset the counter is zero, the timer is stopped, the low-power oscillator is selected with a rate of 32.768 kHz (whole part 32, fraction 16'hC49B), and `irq` and `pwrup_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 32 | Key in [31:16], payload in [15:0] |
| rd_addr | input | 4 | Read address: 0 control/status, 1 time low, 2 time high |
| rd_data | output | 32 | Read data |
| lposc_stb | input | 1 | One-cycle strobe per low-power oscillator period |
| xosc_stb | input | 1 | One-cycle strobe per crystal oscillator period |
| tick_pins | input | PIN_W | External pins that may carry a 1 kHz tick |
| irq | output | 1 | Latched alarm interrupt |
| pwrup_req | output | 1 | Power-up request from the alarm |

## Verification
The bench drives a divider set to 3.5 kHz and checks that the ticks fall on the 4th strobe and then on the 3rd. A divider that dropped the kept excess, or that rounded the setting, would put a tick on the wrong strobe. It also checks that the default 32.768 kHz rate first ticks on the 33rd strobe and not the 32nd.

During a source switch, the bench confirms that the old source still counts while the in-use flags read zero. After the switch, it confirms that only the new pin produces ticks, so a design that lost or doubled a tick at the changeover would be off by one.

It also checks that the alarm and time slices are locked while they should be, that an ignored pin index leaves the old pin in force, and that the interrupt stays latched after the alarm is disabled until it is cleared. Each of these faults shows as a counter, interrupt or power-up value that differs from the expected one.

// File: rtl/aon_timer_pkg.sv
// Shared types and register addresses for the always-on millisecond timer.
// Assumes a 4-bit register address space and three tick sources.
package aon_timer_pkg;

    typedef enum logic [1:0] {
        SRC_LPOSC  = 2'd0,
        SRC_XOSC   = 2'd1,
        SRC_EXTPIN = 2'd2
    } tick_src_e;

    localparam logic [3:0] ADDR_CTRL    = 4'd0;
    localparam logic [3:0] ADDR_TIME0   = 4'd1;
    localparam logic [3:0] ADDR_TIME3   = 4'd4;
    localparam logic [3:0] ADDR_ALRM0   = 4'd5;
    localparam logic [3:0] ADDR_ALRM3   = 4'd8;
    localparam logic [3:0] ADDR_LP_INT  = 4'd9;
    localparam logic [3:0] ADDR_LP_FRAC = 4'd10;
    localparam logic [3:0] ADDR_XO_INT  = 4'd11;
    localparam logic [3:0] ADDR_XO_FRAC = 4'd12;
    localparam logic [3:0] ADDR_PIN     = 4'd13;
    localparam logic [3:0] ADDR_IRQ_CLR = 4'd14;

    localparam logic [3:0] RADDR_CTRL    = 4'd0;
    localparam logic [3:0] RADDR_TIME_LO = 4'd1;
    localparam logic [3:0] RADDR_TIME_HI = 4'd2;

    // One-hot view of a source, bit order matches the select field.
    function automatic logic [2:0] src_onehot(tick_src_e s);
        return 3'b001 << s;
    endfunction

endpackage

// File: rtl/aon_frac_div.sv
// Fractional divider: turns an oscillator strobe into a 1 kHz tick.
// The accumulator gains 1.0 per strobe; on reaching the programmed
// whole.fraction period it ticks and keeps the excess. Assumes strobes
// are single-cycle and synchronous to clk. Cleared when not enabled.
module aon_frac_div #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              strobe,
    input  logic [INT_W-1:0]  per_int,
    input  logic [FRAC_W-1:0] per_frac,
    output logic              tick
);
    localparam int ACC_W = INT_W + FRAC_W + 1;
    localparam logic [ACC_W-1:0] UNIT = {{INT_W{1'b0}}, 1'b1, {FRAC_W{1'b0}}};

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_inc;
    logic [ACC_W-1:0] period;
    logic             hit;

    // Next accumulator value and tick decision for this strobe.
    always_comb begin
        acc_inc = acc_q + UNIT;
        period  = {1'b0, per_int, per_frac};
        hit     = enable && strobe && (period != '0) && (acc_inc >= period);
    end

    assign tick = hit;

    // Accumulate per strobe, subtract the period on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            acc_q <= '0;
        end else if (strobe) begin
            acc_q <= hit ? (acc_inc - period) : acc_inc;
        end
    end

    // R5: with a period of at least 1.0 the kept excess stays below the period
    a_r5_excess_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        hit && (per_int != '0) |=> (acc_q < {1'b0, $past(per_int), $past(per_frac)}) || !enable);

endmodule

// File: rtl/aon_tick_select.sv
// Tick source selection with a delayed switch-over and in-use flags.
// The pin source is synchronised by two flops and edge-detected. During
// a switch the old source keeps ticking for SW_DELAY cycles; the in-use
// flags read zero until the new source takes over. Assumes SW_DELAY >= 1.
module aon_tick_select
    import aon_timer_pkg::*;
#(
    parameter int PIN_W    = 24,
    parameter int SW_DELAY = 3,
    parameter int IDX_W    = $clog2(PIN_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sel_wr,
    input  tick_src_e        sel_new,
    input  logic             lp_tick,
    input  logic             xo_tick,
    input  logic [PIN_W-1:0] pins,
    input  logic [IDX_W-1:0] pin_idx,
    output logic             tick,
    output tick_src_e        act_src,
    output tick_src_e        req_src,
    output logic [2:0]       using_src
);
    localparam int CNT_W = $clog2(SW_DELAY + 1);

    tick_src_e  act_q, req_q;
    logic [CNT_W-1:0] cnt_q;
    logic sync1_q, sync2_q, prev_q;
    logic ext_tick;

    // Two-flop synchroniser and edge history for the chosen pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= pins[pin_idx];
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign ext_tick = sync2_q && !prev_q;

    // Request capture and countdown to the switch-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= SRC_LPOSC;
            req_q <= SRC_LPOSC;
            cnt_q <= '0;
        end else if (sel_wr) begin
            req_q <= sel_new;
            cnt_q <= (sel_new != act_q) ? CNT_W'(SW_DELAY) : '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) act_q <= req_q;
        end
    end

    // Route the active source's tick.
    always_comb begin
        unique case (act_q)
            SRC_XOSC:   tick = xo_tick;
            SRC_EXTPIN: tick = ext_tick;
            default:    tick = lp_tick;
        endcase
    end

    assign act_src   = act_q;
    assign req_src   = req_q;
    assign using_src = (run && cnt_q == '0) ? src_onehot(act_q) : 3'b000;

    // R7: at most one in-use flag at a time
    a_r7_using_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(using_src));
    // R7: a switch to another source drops the in-use flags next cycle
    a_r7_switch_clears_using: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr && (sel_new != act_q) |=> using_src == 3'b000);
    // R7: the active source only changes when the countdown expires
    a_r7_act_changes_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_W'(1)) |=> $stable(act_q));

endmodule

// File: rtl/aon_alarm.sv
// 64-bit alarm comparator with a latched interrupt and power-up request.
// Slices are writable only while the alarm is disabled. A clear wins over
// a new firing in the same cycle. Assumes TIME_W is a multiple of 16.
module aon_alarm #(
    parameter int TIME_W = 64,
    parameter int SLC_W  = 16,
    parameter int NSLC   = TIME_W / SLC_W,
    parameter int SIDX_W = $clog2(NSLC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slice_wr,
    input  logic [SIDX_W-1:0] slice_idx,
    input  logic [SLC_W-1:0]  slice_data,
    input  logic              alarm_en,
    input  logic              pwrup_en,
    input  logic              clr,
    input  logic [TIME_W-1:0] count,
    output logic              irq,
    output logic              pwrup_req
);
    logic [TIME_W-1:0] alarm_q;
    logic              status_q;

    // One register per slice, loaded only while the alarm is off.
    for (genvar g = 0; g < NSLC; g++) begin : g_slice
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                alarm_q[g*SLC_W +: SLC_W] <= '0;
            end else if (slice_wr && !alarm_en && slice_idx == SIDX_W'(g)) begin
                alarm_q[g*SLC_W +: SLC_W] <= slice_data;
            end
        end
    end

    // Latch the alarm status; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            status_q <= 1'b0;
        end else if (alarm_en && count >= alarm_q) begin
            status_q <= 1'b1;
        end
    end

    assign irq       = status_q;
    assign pwrup_req = status_q && pwrup_en;

    // R8: alarm time frozen while enabled
    a_r8_locked_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_en |=> $stable(alarm_q));
    // R9: reaching the alarm time while enabled raises irq
    a_r9_fires: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_en && (count >= alarm_q) && !clr |=> irq);
    // R9: irq stays latched until cleared
    a_r9_latched: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr |=> irq);
    // R10: a power-up request only accompanies an interrupt
    a_r10_pwrup_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        pwrup_req |-> irq);

endmodule

// File: rtl/aon_ms_timer.sv
// Always-on millisecond timer top: key-checked register port, 64-bit
// counter, two fractional oscillator dividers, a pin tick source with a
// delayed switch-over, and an alarm. Assumes TIME_W = 64 (four slices)
// and that oscillator strobes are synchronous one-cycle pulses.
module aon_ms_timer
    import aon_timer_pkg::*;
#(
    parameter int          TIME_W      = 64,
    parameter int          INT_W       = 16,
    parameter int          FRAC_W      = 16,
    parameter int          PIN_W       = 24,
    parameter int          SW_DELAY    = 3,
    parameter logic [15:0] PASSWORD    = 16'h5AFE,
    parameter int          LP_INT_RST  = 32,
    parameter int          LP_FRAC_RST = 16'hC49B,
    parameter int          XO_INT_RST  = 12000,
    parameter int          XO_FRAC_RST = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [3:0]       rd_addr,
    output logic [31:0]      rd_data,
    input  logic             lposc_stb,
    input  logic             xosc_stb,
    input  logic [PIN_W-1:0] tick_pins,
    output logic             irq,
    output logic             pwrup_req
);
    localparam int SLC_W = 16;
    localparam int NSLC  = TIME_W / SLC_W;
    localparam int IDX_W = $clog2(PIN_W);

    logic              wr_ok;
    logic [15:0]       pay;
    logic              run_q, alarm_en_q, pwrup_en_q;
    logic [INT_W-1:0]  lp_int_q, xo_int_q;
    logic [FRAC_W-1:0] lp_frac_q, xo_frac_q;
    logic [IDX_W-1:0]  pin_idx_q;
    logic [TIME_W-1:0] count_q;
    logic              time_wr, alarm_wr, ctrl_wr, sel_wr, pin_ok;
    tick_src_e         sel_new, act_src, req_src;
    logic [2:0]        using_src;
    logic              lp_tick, xo_tick, tick;

    // Key check and address decode.
    always_comb begin
        wr_ok    = wr_en && (wr_data[31:16] == PASSWORD);
        pay      = wr_data[15:0];
        ctrl_wr  = wr_ok && wr_addr == ADDR_CTRL;
        time_wr  = wr_ok && wr_addr >= ADDR_TIME0 && wr_addr <= ADDR_TIME3;
        alarm_wr = wr_ok && wr_addr >= ADDR_ALRM0 && wr_addr <= ADDR_ALRM3;
        sel_wr   = ctrl_wr && (pay[2:0] != 3'b000);
        sel_new  = pay[2] ? SRC_EXTPIN : (pay[1] ? SRC_XOSC : SRC_LPOSC);
        pin_ok   = (pay == 16'd12) || (pay == 16'd14) || (pay == 16'd20) || (pay == 16'd22);
    end

    // Control and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            alarm_en_q <= 1'b0;
            pwrup_en_q <= 1'b0;
            lp_int_q   <= INT_W'(LP_INT_RST);
            lp_frac_q  <= FRAC_W'(LP_FRAC_RST);
            xo_int_q   <= INT_W'(XO_INT_RST);
            xo_frac_q  <= FRAC_W'(XO_FRAC_RST);
            pin_idx_q  <= IDX_W'(12);
        end else if (wr_ok) begin
            unique case (wr_addr)
                ADDR_CTRL: begin
                    run_q      <= pay[3];
                    alarm_en_q <= pay[4];
                    pwrup_en_q <= pay[5];
                end
                ADDR_LP_INT:  lp_int_q  <= INT_W'(pay);
                ADDR_LP_FRAC: lp_frac_q <= FRAC_W'(pay);
                ADDR_XO_INT:  xo_int_q  <= INT_W'(pay);
                ADDR_XO_FRAC: xo_frac_q <= FRAC_W'(pay);
                ADDR_PIN:     if (pin_ok && pay < 16'(PIN_W)) pin_idx_q <= IDX_W'(pay);
                default: ;
            endcase
        end
    end

    // Millisecond counter: slice loads while stopped, else count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (time_wr && !run_q) begin
            count_q[SLC_W*(2'(wr_addr - ADDR_TIME0)) +: SLC_W] <= pay;
        end else if (run_q && tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    aon_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_lp_div (
        .clk(clk), .rst_n(rst_n),
        .enable(run_q && act_src == SRC_LPOSC),
        .strobe(lposc_stb), .per_int(lp_int_q), .per_frac(lp_frac_q),
        .tick(lp_tick)
    );

    aon_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_xo_div (
        .clk(clk), .rst_n(rst_n),
        .enable(run_q && act_src == SRC_XOSC),
        .strobe(xosc_stb), .per_int(xo_int_q), .per_frac(xo_frac_q),
        .tick(xo_tick)
    );

    aon_tick_select #(.PIN_W(PIN_W), .SW_DELAY(SW_DELAY), .IDX_W(IDX_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .run(run_q),
        .sel_wr(sel_wr), .sel_new(sel_new),
        .lp_tick(lp_tick), .xo_tick(xo_tick),
        .pins(tick_pins), .pin_idx(pin_idx_q),
        .tick(tick), .act_src(act_src), .req_src(req_src), .using_src(using_src)
    );

    aon_alarm #(.TIME_W(TIME_W), .SLC_W(SLC_W), .NSLC(NSLC)) u_alarm (
        .clk(clk), .rst_n(rst_n),
        .slice_wr(alarm_wr), .slice_idx(2'(wr_addr - ADDR_ALRM0)), .slice_data(pay),
        .alarm_en(alarm_en_q), .pwrup_en(pwrup_en_q),
        .clr(wr_ok && wr_addr == ADDR_IRQ_CLR && pay[0]),
        .count(count_q), .irq(irq), .pwrup_req(pwrup_req)
    );

    // Read multiplexer.
    always_comb begin
        unique case (rd_addr)
            RADDR_CTRL:    rd_data = {19'd0, irq, 1'b0, using_src, 2'b00,
                                      pwrup_en_q, alarm_en_q, run_q, src_onehot(req_src)};
            RADDR_TIME_LO: rd_data = count_q[31:0];
            RADDR_TIME_HI: rd_data = count_q[63:32];
            default:       rd_data = '0;
        endcase
    end

    // R1: a write with the wrong key leaves control unchanged
    a_r1_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_data[31:16] != PASSWORD) |=>
            $stable(run_q) && $stable(alarm_en_q) && $stable(pin_idx_q));
    // R4: without a slice load the counter moves by zero or one
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !time_wr |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1));
    // R4: a stopped counter holds
    a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q && !time_wr |=> $stable(count_q));

endmodule

// File: tb/aon_ms_timer_tb_top.sv
// Directed bench for the always-on millisecond timer.
module aon_ms_timer_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          PIN_W      = 24;
    localparam int          SW_DELAY   = 3;
    localparam logic [15:0] KEY        = 16'h5AFE;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [3:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic [3:0]       rd_addr = '0;
    logic [31:0]      rd_data;
    logic             lposc_stb = 1'b0;
    logic             xosc_stb = 1'b0;
    logic [PIN_W-1:0] tick_pins = '0;
    logic             irq, pwrup_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aon_ms_timer #(.PIN_W(PIN_W), .SW_DELAY(SW_DELAY), .PASSWORD(KEY)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .lposc_stb(lposc_stb), .xosc_stb(xosc_stb),
        .tick_pins(tick_pins), .irq(irq), .pwrup_req(pwrup_req)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d, logic [15:0] k = KEY);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = {k, d};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic lp_pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); lposc_stb = 1'b1;
            @(negedge clk); lposc_stb = 1'b0;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic time_lo(string req, logic [31:0] exp);
        logic [31:0] v;
        rd(4'd1, v);
        check(req, v, exp);
    endtask

    task automatic load_time(logic [63:0] t);
        for (int s = 0; s < 4; s++) wr(4'(1 + s), t[16*s +: 16]);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'd0, v);  check("R11 ctrl after reset", v, 32'h1);
        rd(4'd1, v);  check("R11 time lo after reset", v, 0);
        rd(4'd2, v);  check("R11 time hi after reset", v, 0);
        check("R11 irq after reset", irq, 0);
        check("R11 pwrup after reset", pwrup_req, 0);
    endtask

    task automatic t_key;
        logic [31:0] v;
        wr(4'd0, 16'h0009, 16'h1234);
        rd(4'd0, v);  check("R1 ctrl unchanged by bad key", v, 32'h1);
        wr(4'd1, 16'hBEEF, 16'h0000);
        time_lo("R1 time unchanged by bad key", 0);
    endtask

    task automatic t_load;
        logic [31:0] v;
        load_time(64'h0001_0002_0003_0004);
        rd(4'd1, v);  check("R2 R3 time lo after load", v, 32'h0003_0004);
        rd(4'd2, v);  check("R2 R3 time hi after load", v, 32'h0001_0002);
    endtask

    task automatic t_default_rate;
        logic [31:0] v;
        load_time(64'd0);
        wr(4'd0, 16'h0009);
        rd(4'd0, v);  check("R7 R11 low-power in use", v, 32'h109);
        lp_pulses(32);
        time_lo("R11 no tick after 32 strobes", 0);
        lp_pulses(1);
        time_lo("R11 R4 tick on 33rd strobe", 1);
    endtask

    task automatic t_fraction;
        wr(4'd0, 16'h0001);
        lp_pulses(2);
        time_lo("R4 stopped counter holds", 1);
        wr(4'd9, 16'd3);
        wr(4'd10, 16'h8000);
        wr(4'd0, 16'h0009);
        lp_pulses(3);
        time_lo("R5 no tick after 3 strobes", 1);
        lp_pulses(1);
        time_lo("R5 tick on 4th strobe", 2);
        lp_pulses(2);
        time_lo("R5 no tick 2 strobes later", 2);
        lp_pulses(1);
        time_lo("R5 carried excess ticks on 3rd", 3);
        wr(4'd1, 16'h0055);
        time_lo("R2 slice write ignored while running", 3);
    endtask

    task automatic t_switch;
        logic [31:0] v;
        wr(4'd13, 16'd20);
        wr(4'd13, 16'd13);
        wr(4'd9, 16'd1);
        wr(4'd10, 16'd0);
        lp_pulses(1);
        time_lo("R5 whole period one", 4);
        wr(4'd0, 16'h000C);
        rd_addr = 4'd0;
        #1 check("R7 in-use flags clear while pending", rd_data, 32'h0000_000C);
        @(negedge clk); lposc_stb = 1'b1;
        @(negedge clk); lposc_stb = 1'b0;
        time_lo("R7 old source ticks during switch", 5);
        idle(SW_DELAY);
        rd(4'd0, v);  check("R7 pin source in use", v, 32'h40C);
        lp_pulses(2);
        time_lo("R7 old source ignored after switch", 5);
        @(negedge clk); tick_pins[13] = 1'b1;
        idle(5);
        time_lo("R6 rejected pin index has no effect", 5);
        @(negedge clk); tick_pins[20] = 1'b1;
        idle(5);
        time_lo("R6 rising edge on chosen pin ticks", 6);
        idle(5);
        time_lo("R6 steady high gives one tick", 6);
    endtask

    task automatic t_alarm;
        wr(4'd0, 16'h0001);
        idle(SW_DELAY + 1);
        load_time(64'h10);
        for (int s = 0; s < 4; s++) wr(4'(5 + s), (s == 0) ? 16'h0014 : 16'h0000);
        wr(4'd0, 16'h0039);
        wr(4'd5, 16'h0100);
        idle(2);
        check("R9 no irq before alarm time", irq, 0);
        lp_pulses(3);
        idle(2);
        check("R9 no irq one below alarm", irq, 0);
        lp_pulses(1);
        idle(2);
        check("R8 R9 irq at alarm time", irq, 1);
        check("R10 pwrup with enable", pwrup_req, 1);
        wr(4'd0, 16'h0009);
        idle(2);
        check("R9 irq latched after disable", irq, 1);
        wr(4'd14, 16'h0001);
        check("R9 irq cleared", irq, 0);
        check("R10 pwrup follows irq", pwrup_req, 0);
        wr(4'd0, 16'h0019);
        idle(2);
        check("R9 refire past alarm", irq, 1);
        check("R10 no pwrup when disabled", pwrup_req, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset;
        t_key;
        t_load;
        t_default_rate;
        t_fraction;
        t_switch;
        t_alarm;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule